// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects level-sensitive interrupt lines from a set of devices and hands them to a small number of processor contexts. Each context has its own interrupt-request output. Software configures the block through a single-cycle register port that takes byte addresses. It sets a priority for each source, an enable mask for each context and a threshold for each context. A context is interrupted only by a source that is pending, is enabled for that context, and has a priority strictly above that context's threshold.

A handler takes an interrupt in two steps. It reads its context's claim/complete register, which returns the ID of the best eligible source and marks that source as taken. When the service is finished, it writes the same ID back to the same register. While a source is taken, its gateway does not raise a new request for it. Once completion is written, a line that is still asserted becomes pending again. Source ID 0 is reserved. A claim read that returns 0 means the context has nothing pending.

Top module: `plic_core`

## Requirements
- R1: After reset every priority, enable, threshold and pending bit is 0, every interrupt output is low, and a claim read returns 0.
- R2: The priority of source n (1..NSRC) is held in PRIO_W bits at byte address 4·n and reads back zero-extended. Address 0 (source 0) always reads 0 and ignores writes.
- R3: The enable bit of source n for context c is bit (n mod 32) of the word at byte address 0x2000 + 0x80·c + 4·(n div 32). Bit 0 of word 0 (source 0) always reads 0.
- R4: The threshold of context c (PRIO_W bits, read back zero-extended) is at byte address 0x200000 + 0x1000·c, and its claim/complete register is 4 bytes above it. Address bits 1:0 are ignored everywhere.
- R5: A context's output is high only while some pending, enabled source has a priority strictly greater than that context's threshold. A source of priority 0 never raises an output.
- R6: Among eligible sources, the claim read returns the one with the highest priority, and a tie goes to the lowest source ID.
- R7: A claim read returns the winning ID and clears that source's pending bit in the same cycle. With no eligible source it returns 0 and changes nothing. Read data appears on bus_rdata one clock after bus_re.
- R8: A claimed source is not presented again until its completion is written. If its line is still high after completion, it becomes pending again.
- R9: A completion write is ignored when its ID is 0, is above NSRC, or is not currently claimed by the context written to.
- R10: A threshold of all ones masks every source for that context.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.
- R12: Enables, thresholds and claims are per context. A source enabled only on one context raises only that context's output, and only that context can claim it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt lines; bit n is source n (index range NSRC:1) |
| bus_we | input | 1 | Write strobe for the register port |
| bus_re | input | 1 | Read strobe for the register port |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_re |
| irq_o | output | NCTX | Interrupt request to each context |

## Verification
The bench builds the block with its defaults: 31 sources, 2 contexts, 3-bit priorities and a 24-bit address. With 31 sources the whole enable set fits in one word, so the bench can probe the absent second enable word as unmapped space. With two contexts, cross-context completion and per-context masking can be tested. The 3-bit priority lets a write of all ones show truncation, and it makes the all-ones threshold reachable as the full mask. Ties and strict-greater cases are driven at priority values the bench picks by hand.

// File: rtl/plic_pkg.sv
package plic_pkg;

   localparam logic [31:0] EN_BASE   = 32'h0000_2000;
   localparam logic [31:0] CP_BASE   = 32'h0020_0000;
   localparam logic [31:0] PRIO_SPAN = 32'h0000_1000;
   localparam int          EN_LG     = 7;
   localparam int          CP_LG     = 12;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_PRIO,
      RGN_EN,
      RGN_THR,
      RGN_CLM
   } rgn_e;

   function automatic int lg_min1(input int v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
   import plic_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int NCTX = 2,
   localparam int NBIT = NSRC + 1,
   localparam int ID_W = lg_min1(NBIT),
   localparam int CTX_W = lg_min1(NCTX)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC:1]          src_i,
   input  logic                   claim_fire_i,
   input  logic [CTX_W-1:0]       claim_ctx_i,
   input  logic [ID_W-1:0]        claim_id_i,
   input  logic                   done_fire_i,
   input  logic [CTX_W-1:0]       done_ctx_i,
   input  logic [ID_W-1:0]        done_id_i,
   output logic [NBIT-1:0]        pend_o,
   output logic [NCTX*NBIT-1:0]   owned_o
);

   assign pend_o[0] = 1'b0;

   for (genvar c = 0; c < NCTX; c++) begin : g_zero
      assign owned_o[c*NBIT] = 1'b0;
   end

   for (genvar i = 1; i < NBIT; i++) begin : g_src
      logic            pend_q;
      logic [NCTX-1:0] own_q;
      logic            take;
      logic            give;

      assign take = claim_fire_i && (claim_id_i == ID_W'(i));
      assign give = done_fire_i && (done_id_i == ID_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
         end else if (take) begin
            pend_q <= 1'b0;
         end else if (src_i[i] && !(|own_q)) begin
            pend_q <= 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            own_q <= '0;
         end else begin
            for (int c = 0; c < NCTX; c++) begin
               if (take && claim_ctx_i == CTX_W'(c)) begin
                  own_q[c] <= 1'b1;
               end else if (give && done_ctx_i == CTX_W'(c)) begin
                  own_q[c] <= 1'b0;
               end
            end
         end
      end

      assign pend_o[i] = pend_q;
      for (genvar c = 0; c < NCTX; c++) begin : g_own
         assign owned_o[c*NBIT+i] = own_q[c];
      end
   end

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter
   import plic_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int PRIO_W = 3,
   localparam int NBIT = NSRC + 1,
   localparam int ID_W = lg_min1(NBIT)
) (
   input  logic [NBIT-1:0]        pend_i,
   input  logic [NBIT-1:0]        en_i,
   input  logic [NBIT*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]      thr_i,
   output logic [ID_W-1:0]        id_o,
   output logic                   irq_o
);

   logic [PRIO_W-1:0] best_p;
   logic [ID_W-1:0]   best_id;

   // The running best starts at the threshold, so the strict compare
   // applies the gate, rejects priority 0, and keeps the lower ID on a tie.
   always_comb begin
      best_p  = thr_i;
      best_id = '0;
      for (int i = 1; i < NBIT; i++) begin
         if (pend_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
            best_p  = prio_i[i*PRIO_W +: PRIO_W];
            best_id = ID_W'(i);
         end
      end
   end

   assign id_o  = best_id;
   assign irq_o = (best_id != '0);

endmodule

// File: rtl/plic_regfile.sv
module plic_regfile
   import plic_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int NCTX = 2,
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 24,
   localparam int NBIT = NSRC + 1,
   localparam int ID_W = lg_min1(NBIT),
   localparam int CTX_W = lg_min1(NCTX),
   localparam int NWORD = (NBIT + 31) / 32,
   localparam int WD_W = lg_min1(NWORD)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_we,
   input  logic                   bus_re,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   output logic [NBIT*PRIO_W-1:0] prio_o,
   output logic [NCTX*NBIT-1:0]   en_o,
   output logic [NCTX*PRIO_W-1:0] thr_o,
   input  logic [NCTX*ID_W-1:0]   best_i,
   input  logic [NCTX*NBIT-1:0]   owned_i,
   output logic                   claim_fire_o,
   output logic [CTX_W-1:0]       claim_ctx_o,
   output logic [ID_W-1:0]        claim_id_o,
   output logic                   done_fire_o,
   output logic [CTX_W-1:0]       done_ctx_o,
   output logic [ID_W-1:0]        done_id_o
);

   localparam logic [31:0] NSRC_L  = 32'(NSRC);
   localparam logic [31:0] NWORD_L = 32'(NWORD);
   localparam logic [31:0] EN_SPAN = 32'(NCTX) << EN_LG;
   localparam logic [31:0] CP_SPAN = 32'(NCTX) << CP_LG;

   logic [PRIO_W-1:0]  prio_q [NBIT];
   logic [NBIT-1:0]    en_q   [NCTX];
   logic [PRIO_W-1:0]  thr_q  [NCTX];
   logic [NWORD*32-1:0] en_pad [NCTX];
   logic [ID_W-1:0]    best_a [NCTX];

   logic [31:0]        a32, en_off, cp_off, pidx, widx;
   rgn_e               rgn;
   logic [ID_W-1:0]    idx;
   logic [CTX_W-1:0]   ctx;
   logic [WD_W-1:0]    word;
   logic               id_ok;

   // ---------------- address decode ----------------
   assign a32    = 32'(bus_addr);
   assign en_off = a32 - EN_BASE;
   assign cp_off = a32 - CP_BASE;
   assign pidx   = {22'd0, a32[11:2]};
   assign widx   = {27'd0, en_off[6:2]};

   always_comb begin
      rgn  = RGN_NONE;
      idx  = '0;
      ctx  = '0;
      word = '0;
      if (a32 < PRIO_SPAN) begin
         if (pidx >= 32'd1 && pidx <= NSRC_L) begin
            rgn = RGN_PRIO;
            idx = ID_W'(pidx);
         end
      end else if (a32 >= EN_BASE && en_off < EN_SPAN) begin
         if (widx < NWORD_L) begin
            rgn  = RGN_EN;
            ctx  = CTX_W'(en_off >> EN_LG);
            word = WD_W'(widx);
         end
      end else if (a32 >= CP_BASE && cp_off < CP_SPAN) begin
         ctx = CTX_W'(cp_off >> CP_LG);
         if (cp_off[11:2] == 10'd0) begin
            rgn = RGN_THR;
         end else if (cp_off[11:2] == 10'd1) begin
            rgn = RGN_CLM;
         end
      end
   end

   // ---------------- storage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NBIT; i++) prio_q[i] <= '0;
         for (int c = 0; c < NCTX; c++) begin
            en_q[c]  <= '0;
            thr_q[c] <= '0;
         end
      end else if (bus_we) begin
         case (rgn)
            RGN_PRIO: prio_q[idx] <= bus_wdata[PRIO_W-1:0];
            RGN_EN: begin
               for (int b = 1; b < NBIT; b++) begin
                  if ((b >> 5) == int'(word)) en_q[ctx][b] <= bus_wdata[b & 31];
               end
            end
            RGN_THR: thr_q[ctx] <= bus_wdata[PRIO_W-1:0];
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NBIT; i++) begin : g_prio_out
      assign prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
   end

   for (genvar c = 0; c < NCTX; c++) begin : g_ctx_out
      assign en_o[c*NBIT +: NBIT]      = en_q[c];
      assign thr_o[c*PRIO_W +: PRIO_W] = thr_q[c];
      assign best_a[c]                 = best_i[c*ID_W +: ID_W];
   end

   always_comb begin
      for (int c = 0; c < NCTX; c++) begin
         en_pad[c]           = '0;
         en_pad[c][NBIT-1:0] = en_q[c];
      end
   end

   // ---------------- claim / complete ----------------
   assign claim_fire_o = bus_re && (rgn == RGN_CLM) && (best_a[ctx] != '0);
   assign claim_ctx_o  = ctx;
   assign claim_id_o   = best_a[ctx];

   assign id_ok       = (bus_wdata >= 32'd1) && (bus_wdata <= NSRC_L);
   assign done_fire_o = bus_we && (rgn == RGN_CLM) && id_ok
                        && owned_i[int'(ctx)*NBIT + int'(bus_wdata[ID_W-1:0])];
   assign done_ctx_o  = ctx;
   assign done_id_o   = bus_wdata[ID_W-1:0];

   // ---------------- read port ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_re) begin
         case (rgn)
            RGN_PRIO: bus_rdata <= 32'(prio_q[idx]);
            RGN_EN:   bus_rdata <= en_pad[ctx][int'(word)*32 +: 32];
            RGN_THR:  bus_rdata <= 32'(thr_q[ctx]);
            RGN_CLM:  bus_rdata <= 32'(best_a[ctx]);
            default:  bus_rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/plic_core.sv
module plic_core
   import plic_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int NCTX = 2,
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 24,
   localparam int NBIT = NSRC + 1,
   localparam int ID_W = lg_min1(NBIT),
   localparam int CTX_W = lg_min1(NCTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC:1]     src_i,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCTX-1:0]   irq_o
);

   // ---------------- elaboration checks ----------------
   if (NSRC < 1 || NSRC > 1023) begin : g_bad_nsrc
      $error("plic_core: NSRC must lie in 1..1023");
   end
   if (NCTX < 1 || NCTX > 512) begin : g_bad_nctx
      $error("plic_core: NCTX must lie in 1..512");
   end
   if (PRIO_W < 1 || PRIO_W > 32) begin : g_bad_prio
      $error("plic_core: PRIO_W must lie in 1..32");
   end
   if (ADDR_W > 32 || (64'(CP_BASE) + 64'(NCTX) * 64'h1000) > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("plic_core: ADDR_W cannot reach every context page");
   end

   logic [NBIT*PRIO_W-1:0] prio_flat;
   logic [NCTX*NBIT-1:0]   en_flat;
   logic [NCTX*PRIO_W-1:0] thr_flat;
   logic [NCTX*ID_W-1:0]   best_flat;
   logic [NCTX*NBIT-1:0]   owned;
   logic [NBIT-1:0]        pend;
   logic                   claim_fire, done_fire;
   logic [CTX_W-1:0]       claim_ctx, done_ctx;
   logic [ID_W-1:0]        claim_id, done_id;

   plic_regfile #(
      .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_we       (bus_we),
      .bus_re       (bus_re),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .prio_o       (prio_flat),
      .en_o         (en_flat),
      .thr_o        (thr_flat),
      .best_i       (best_flat),
      .owned_i      (owned),
      .claim_fire_o (claim_fire),
      .claim_ctx_o  (claim_ctx),
      .claim_id_o   (claim_id),
      .done_fire_o  (done_fire),
      .done_ctx_o   (done_ctx),
      .done_id_o    (done_id)
   );

   plic_gateway #(
      .NSRC(NSRC), .NCTX(NCTX)
   ) u_gw (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (src_i),
      .claim_fire_i (claim_fire),
      .claim_ctx_i  (claim_ctx),
      .claim_id_i   (claim_id),
      .done_fire_i  (done_fire),
      .done_ctx_i   (done_ctx),
      .done_id_i    (done_id),
      .pend_o       (pend),
      .owned_o      (owned)
   );

   for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      plic_arbiter #(
         .NSRC(NSRC), .PRIO_W(PRIO_W)
      ) u_arb (
         .pend_i (pend),
         .en_i   (en_flat[c*NBIT +: NBIT]),
         .prio_i (prio_flat),
         .thr_i  (thr_flat[c*PRIO_W +: PRIO_W]),
         .id_o   (best_flat[c*ID_W +: ID_W]),
         .irq_o  (irq_o[c])
      );
   end

endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk
   import plic_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int NCTX = 2,
   parameter int PRIO_W = 3,
   localparam int NBIT = NSRC + 1,
   localparam int ID_W = lg_min1(NBIT),
   localparam int CTX_W = lg_min1(NCTX)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NCTX-1:0]        irq_i,
   input logic [NBIT-1:0]        pend_i,
   input logic [NCTX*NBIT-1:0]   owned_i,
   input logic [NCTX*ID_W-1:0]   best_i,
   input logic [NCTX*PRIO_W-1:0] thr_i,
   input logic [NBIT*PRIO_W-1:0] prio_i,
   input logic                   claim_fire_i,
   input logic [CTX_W-1:0]       claim_ctx_i,
   input logic [ID_W-1:0]        claim_id_i,
   input logic                   done_fire_i,
   input logic [CTX_W-1:0]       done_ctx_i,
   input logic [ID_W-1:0]        done_id_i
);

   logic [NBIT-1:0] taken;

   always_comb begin
      taken = '0;
      for (int c = 0; c < NCTX; c++) taken = taken | owned_i[c*NBIT +: NBIT];
   end

   // R1: outputs are quiet in the first cycle out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_i == '0));

   // R8: a source is never pending while some context holds it
   a_r8_no_pend_while_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i & taken) == '0);

   // R7: a claim clears the pending bit and records the owner
   a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
      claim_fire_i |=> !pend_i[$past(claim_id_i)]);

   a_r7_claim_owns: assert property (@(posedge clk) disable iff (!rst_n)
      claim_fire_i |=> owned_i[int'($past(claim_ctx_i))*NBIT + int'($past(claim_id_i))]);

   // R9: an accepted completion releases the source for that context
   a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      done_fire_i |=> !owned_i[int'($past(done_ctx_i))*NBIT + int'($past(done_id_i))]);

   for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      logic [ID_W-1:0]   bid;
      logic [PRIO_W-1:0] thr;
      assign bid = best_i[c*ID_W +: ID_W];
      assign thr = thr_i[c*PRIO_W +: PRIO_W];

      // R5: a raised request always has a winner above threshold
      a_r5_irq_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
         irq_i[c] |-> (prio_i[int'(bid)*PRIO_W +: PRIO_W] > thr));

      // R6: the presented winner is a pending source
      a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
         irq_i[c] |-> pend_i[bid]);

      // R10: all-ones threshold masks the context
      a_r10_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
         (thr == '1) |-> !irq_i[c]);
   end

endmodule

bind plic_core plic_core_chk #(
   .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_i        (irq_o),
   .pend_i       (pend),
   .owned_i      (owned),
   .best_i       (best_flat),
   .thr_i        (thr_flat),
   .prio_i       (prio_flat),
   .claim_fire_i (claim_fire),
   .claim_ctx_i  (claim_ctx),
   .claim_id_i   (claim_id),
   .done_fire_i  (done_fire),
   .done_ctx_i   (done_ctx),
   .done_id_i    (done_id)
);

// File: tb/plic_core_tb.sv
`timescale 1ns/1ps
module plic_core_tb;

   localparam int NSRC = 31;
   localparam int NCTX = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC:1]   src = '0;
   logic            we = 1'b0;
   logic            re = 1'b0;
   logic [23:0]     addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NCTX-1:0] irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   plic_core u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_re(re),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] a_prio(input int id);
      return 32'(4 * id);
   endfunction
   function automatic logic [31:0] a_en(input int c);
      return 32'h2000 + 32'(c * 128);
   endfunction
   function automatic logic [31:0] a_thr(input int c);
      return 32'h20_0000 + 32'(c * 4096);
   endfunction
   function automatic logic [31:0] a_clm(input int c);
      return a_thr(c) + 32'd4;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a[23:0]; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      re = 1'b1; addr = a[23:0];
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input string req, input string what,
                         input logic [31:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, what, v, exp);
   endtask

   task automatic t_reset();
      chk("R1", "irq after reset", 32'(irq), 32'd0);
      rd_chk("R1", "prio5 reset", a_prio(5), 32'd0);
      rd_chk("R1", "enable ctx1 reset", a_en(1), 32'd0);
      rd_chk("R1", "thr0 reset", a_thr(0), 32'd0);
      rd_chk("R1", "claim0 reset", a_clm(0), 32'd0);
   endtask

   task automatic t_map();
      wr(a_prio(3), 32'd5);
      rd_chk("R2", "prio3 readback", a_prio(3), 32'd5);
      wr(a_prio(3), 32'hFFFF_FFFF);
      rd_chk("R2", "prio3 truncated", a_prio(3), 32'd7);
      wr(a_prio(0), 32'd6);
      rd_chk("R2", "prio0 fixed", a_prio(0), 32'd0);
      wr(a_en(1), 32'hFFFF_FFFF);
      rd_chk("R3", "enable ctx1 bit0 fixed", a_en(1), 32'hFFFF_FFFE);
      rd_chk("R3", "enable ctx0 untouched", a_en(0), 32'd0);
      wr(a_thr(1), 32'd2);
      rd_chk("R4", "thr1 readback", a_thr(1), 32'd2);
      rd_chk("R4", "thr1 low bits ignored", a_thr(1) + 32'd2, 32'd2);
      wr(a_en(1), 32'd0);
      wr(a_thr(1), 32'd0);
      wr(a_prio(3), 32'd0);
   endtask

   task automatic t_gate();
      src[4] = 1'b1;
      wr(a_prio(4), 32'd2);
      wr(a_en(0), 32'h10);
      wr(a_thr(0), 32'd2);
      idle(2);
      chk("R5", "equal to threshold blocked", 32'(irq[0]), 32'd0);
      rd_chk("R7", "claim with nothing eligible", a_clm(0), 32'd0);
      wr(a_thr(0), 32'd1);
      chk("R5", "above threshold raises", 32'(irq[0]), 32'd1);
      rd_chk("R7", "claim returns 4", a_clm(0), 32'd4);
      src[4] = 1'b0;
      wr(a_clm(0), 32'd4);
      wr(a_thr(0), 32'd0);
      src[6] = 1'b1;
      wr(a_en(0), 32'h40);
      idle(2);
      chk("R5", "priority 0 never fires", 32'(irq[0]), 32'd0);
      src[6] = 1'b0;
      wr(a_en(0), 32'd0);
   endtask

   task automatic t_arb();
      src[3] = 1'b1; src[7] = 1'b1; src[9] = 1'b1;
      wr(a_prio(3), 32'd2);
      wr(a_prio(7), 32'd5);
      wr(a_prio(9), 32'd5);
      wr(a_en(0), 32'h288);
      idle(2);
      chk("R5", "irq with three pending", 32'(irq[0]), 32'd1);
      rd_chk("R6", "highest, lowest ID on tie", a_clm(0), 32'd7);
      rd_chk("R6", "second in tie", a_clm(0), 32'd9);
      rd_chk("R6", "lower priority last", a_clm(0), 32'd3);
      src[7] = 1'b0; src[9] = 1'b0;
      idle(2);
      chk("R8", "claimed not re-presented", 32'(irq[0]), 32'd0);
      rd_chk("R8", "claim while all taken", a_clm(0), 32'd0);
      wr(a_clm(0), 32'd3);
      idle(3);
      rd_chk("R8", "repend after completion", a_clm(0), 32'd3);
      src[3] = 1'b0;
      wr(a_clm(0), 32'd3);
      wr(a_clm(0), 32'd7);
      wr(a_clm(0), 32'd9);
      idle(3);
      chk("R8", "no repend with line low", 32'(irq[0]), 32'd0);
      wr(a_en(0), 32'd0);
   endtask

   task automatic t_badcomplete();
      src[5] = 1'b1;
      wr(a_prio(5), 32'd1);
      wr(a_en(0), 32'h20);
      idle(2);
      rd_chk("R9", "claim 5", a_clm(0), 32'd5);
      wr(a_clm(1), 32'd5);
      wr(a_clm(0), 32'd40);
      wr(a_clm(0), 32'd0);
      idle(3);
      rd_chk("R9", "wrong completions ignored", a_clm(0), 32'd0);
      wr(a_clm(0), 32'd5);
      idle(3);
      rd_chk("R9", "right completion accepted", a_clm(0), 32'd5);
      src[5] = 1'b0;
      wr(a_clm(0), 32'd5);
      wr(a_en(0), 32'd0);
   endtask

   task automatic t_mask();
      src[10] = 1'b1;
      wr(a_prio(10), 32'd7);
      wr(a_en(0), 32'h400);
      idle(2);
      chk("R10", "irq before mask", 32'(irq[0]), 32'd1);
      wr(a_thr(0), 32'hFFFF_FFFF);
      chk("R10", "all ones masks", 32'(irq[0]), 32'd0);
      rd_chk("R10", "masked claim", a_clm(0), 32'd0);
      rd_chk("R10", "thr reads all ones", a_thr(0), 32'd7);
      wr(a_thr(0), 32'd0);
      rd_chk("R10", "unmasked claim", a_clm(0), 32'd10);
      src[10] = 1'b0;
      wr(a_clm(0), 32'd10);
      wr(a_en(0), 32'd0);
   endtask

   task automatic t_unmapped();
      wr(a_prio(2), 32'd3);
      wr(32'h0000_2004, 32'hFFFF_FFFF);
      wr(32'h0000_2100, 32'hFFFF_FFFF);
      wr(32'h0020_0008, 32'hFFFF_FFFF);
      wr(32'h0020_2000, 32'hFFFF_FFFF);
      wr(32'h0000_1000, 32'hFFFF_FFFF);
      rd_chk("R11", "0x1000 reads 0", 32'h0000_1000, 32'd0);
      rd_chk("R11", "enable word 1 reads 0", 32'h0000_2004, 32'd0);
      rd_chk("R11", "enable ctx2 reads 0", 32'h0000_2100, 32'd0);
      rd_chk("R11", "page offset 8 reads 0", 32'h0020_0008, 32'd0);
      rd_chk("R11", "ctx2 page reads 0", 32'h0020_2000, 32'd0);
      rd_chk("R11", "high addr reads 0", 32'h003F_FF00, 32'd0);
      rd_chk("R11", "prio2 unchanged", a_prio(2), 32'd3);
      rd_chk("R11", "en0 unchanged", a_en(0), 32'd0);
      rd_chk("R11", "en1 unchanged", a_en(1), 32'd0);
      rd_chk("R11", "thr0 unchanged", a_thr(0), 32'd0);
      rd_chk("R11", "thr1 unchanged", a_thr(1), 32'd0);
      wr(a_prio(2), 32'd0);
   endtask

   task automatic t_ctx();
      src[12] = 1'b1;
      wr(a_prio(12), 32'd3);
      wr(a_en(1), 32'h1000);
      idle(2);
      chk("R12", "ctx1 raised", 32'(irq[1]), 32'd1);
      chk("R12", "ctx0 quiet", 32'(irq[0]), 32'd0);
      rd_chk("R12", "ctx0 cannot claim", a_clm(0), 32'd0);
      rd_chk("R12", "ctx1 claims 12", a_clm(1), 32'd12);
      src[12] = 1'b0;
      wr(a_clm(1), 32'd12);
      idle(2);
      chk("R12", "ctx1 quiet after complete", 32'(irq[1]), 32'd0);
      wr(a_en(1), 32'd0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_map();
      t_gate();
      t_arb();
      t_badcomplete();
      t_mask();
      t_unmapped();
      t_ctx();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule